// File: doc/BRIEF.md
# Event-to-Interrupt Aggregator

This block gathers event notifications from many sources and folds them into a small number of virtual interrupt lines. Each notification arrives with a global event number and a direction flag (up or down). A programmable lookup table turns the event number into a virtual interrupt index and a bit position. The event then sets or clears one bit of that virtual interrupt's 64-bit status word. For each virtual interrupt, a 64-bit enable word masks the status word. The block drives one interrupt output per virtual interrupt, and that output goes high whenever an enabled status bit is set.

A configuration agent reaches the block through a simple 64-bit register bus. It programs lookup entries and frees them again. It sets and clears enable bits with write-1 registers, reads the status and acknowledges pulsed events with write-1-to-clear. A lookup entry can mark its event as a level event. A level event's status bit follows the source: the up notification sets it and the down notification clears it, so software never has to acknowledge it.

Top module: `evtagg_top`

## Requirements
- R1: Reset clears every status word, every enable word and every lookup-entry valid bit. After reset, all interrupt outputs are low and every register reads zero.
- R2: Virtual interrupt v has its register page at byte address v*0x1000. In that page, offset 0x00 sets enable bits, offset 0x08 clears enable bits and offset 0x18 holds the status word. The lookup entry for event e sits at 0x4000 + 8*e. The entry holds the bit position in [5:0], the virtual interrupt index in [15:8], the level flag in [16] and the valid flag in [31], and reads back the same fields with all other bits zero.
- R3: A write to offset 0x00 sets the enable bits where the write data is one. All other enable bits keep their value.
- R4: A write to offset 0x08 clears the enable bits where the write data is one. A read of offset 0x00 or offset 0x08 returns the current enable word.
- R5: An up event on a valid pulsed entry sets the mapped status bit, and the bit stays set. A down event on a pulsed entry leaves the status unchanged.
- R6: A write to offset 0x18 clears the status bits where the write data is one. All other status bits keep their value.
- R7: An up event on a valid level entry sets the mapped status bit. A down event on that entry clears the bit.
- R8: When an up event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: The status is unchanged by an event whose entry is not valid, or whose entry names a virtual interrupt index at or above the number of virtual interrupts.
- R10: An interrupt output is high in the cycle after the AND of its status and enable words is nonzero. It goes low in the cycle after that AND becomes zero.
- R11: Read data appears on the cycle after the read request. A read of an undefined page offset returns zero, and a write to an undefined offset changes no state.
- R12: A rewritten lookup entry redirects later events to the new virtual interrupt and bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Register access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (15) | Byte address |
| busWdata | input | 64 | Write data |
| busRdata | output | 64 | Read data, one cycle after the request |
| evtValid | input | 1 | Event notification present |
| evtId | input | EVT_W (5) | Global event number |
| evtDown | input | 1 | 1 = down notification, 0 = up |
| irqOut | output | NUM_VINT (4) | One interrupt output per virtual interrupt |

## Verification
The bench programs all 32 lookup entries with distinct bit positions, mixing pulsed and level modes. It then fires up and down events for every event and compares all status words, enable words and outputs against an arithmetic model. If a design applied the acknowledge after the event, the same-cycle collision would lose the event and the status bit would read back zero. Entries that are invalid or point out of range are fired on purpose. A design that did not drop them would corrupt some other virtual interrupt's status. The bench also writes to an undefined page offset, redirects an entry to a new target, and watches the outputs fall one cycle after the enables are cleared. These checks catch aliasing onto the enable registers, stale lookups and an output that is not registered.

// File: rtl/evtagg_pkg.sv
package evtagg_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int WORD_W = 64;
  localparam int BITPOS_W = 6;
  localparam int VIDX_W = 8;

  typedef enum logic [1:0] {
    REG_EN_SET = 2'd0,
    REG_EN_CLR = 2'd1,
    REG_STATUS = 2'd2,
    REG_NONE   = 2'd3
  } regKind_e;

  typedef struct packed {
    logic                regWr;
    regKind_e            regKind;
    logic [VIDX_W-1:0]   page;
    logic                evtSet;
    logic                evtClr;
    logic [VIDX_W-1:0]   evtVint;
    logic [BITPOS_W-1:0] evtBit;
  } dpStrobes_t;
endpackage

// File: rtl/evtagg_ctrl.sv
module evtagg_ctrl
  import evtagg_pkg::*;
#(
  parameter int NUM_VINT   = 4,
  parameter int NUM_EVENTS = 32,
  parameter int VINT_W     = 2,
  parameter int EVT_W      = 5,
  parameter int ADDR_W     = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic              evtValid,
  input  logic [EVT_W-1:0]  evtId,
  input  logic              evtDown,
  input  logic [WORD_W-1:0] pageWord,
  output dpStrobes_t        strb
);
  // map storage
  logic [NUM_EVENTS-1:0] mapValid;
  logic [NUM_EVENTS-1:0] mapLevel;
  logic [VIDX_W-1:0]     mapVint [NUM_EVENTS];
  logic [BITPOS_W-1:0]   mapBit  [NUM_EVENTS];

  // address decode
  logic              mapSpace;
  logic [VINT_W-1:0] pageIdx;
  logic [PAGE_SHIFT-1:0] pageOff;
  logic [EVT_W-1:0]  mapIdx;
  logic              mapHit;
  regKind_e          kind;

  assign mapSpace = busAddr[ADDR_W-1];
  assign pageIdx  = busAddr[PAGE_SHIFT +: VINT_W];
  assign pageOff  = busAddr[PAGE_SHIFT-1:0];
  assign mapIdx   = busAddr[3 +: EVT_W];
  assign mapHit   = mapSpace && (busAddr[2:0] == 3'd0) && (int'(mapIdx) < NUM_EVENTS);

  always_comb begin
    kind = REG_NONE;
    if (!mapSpace && (int'(pageIdx) < NUM_VINT)) begin
      case (pageOff)
        12'h000: kind = REG_EN_SET;
        12'h008: kind = REG_EN_CLR;
        12'h018: kind = REG_STATUS;
        default: kind = REG_NONE;
      endcase
    end
  end

  // map programming
  always_ff @(posedge clk) begin
    if (rst) begin
      mapValid <= '0;
      mapLevel <= '0;
      for (int e = 0; e < NUM_EVENTS; e++) begin
        mapVint[e] <= '0;
        mapBit[e]  <= '0;
      end
    end else if (busValid && busWrite && mapHit) begin
      mapValid[mapIdx] <= busWdata[31];
      mapLevel[mapIdx] <= busWdata[16];
      mapVint[mapIdx]  <= busWdata[15:8];
      mapBit[mapIdx]   <= busWdata[5:0];
    end
  end

  // event lookup
  logic evtOk;
  logic idInRange;
  assign idInRange = int'(evtId) < NUM_EVENTS;

  always_comb begin
    evtOk = 1'b0;
    strb.evtVint = '0;
    strb.evtBit  = '0;
    strb.evtSet  = 1'b0;
    strb.evtClr  = 1'b0;
    if (evtValid && idInRange) begin
      evtOk = mapValid[evtId] && (int'(mapVint[evtId]) < NUM_VINT);
      strb.evtVint = mapVint[evtId];
      strb.evtBit  = mapBit[evtId];
      strb.evtSet  = evtOk && !evtDown;
      strb.evtClr  = evtOk && evtDown && mapLevel[evtId];
    end
    strb.regWr   = busValid && busWrite;
    strb.regKind = kind;
    strb.page    = VIDX_W'(pageIdx);
  end

  // registered read data
  logic [WORD_W-1:0] mapWord;
  always_comb begin
    mapWord = '0;
    if (mapHit) begin
      mapWord[31]   = mapValid[mapIdx];
      mapWord[16]   = mapLevel[mapIdx];
      mapWord[15:8] = mapVint[mapIdx];
      mapWord[5:0]  = mapBit[mapIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busRdata <= '0;
    else if (busValid && !busWrite) busRdata <= mapSpace ? mapWord : pageWord;
  end
endmodule

// File: rtl/evtagg_datapath.sv
module evtagg_datapath
  import evtagg_pkg::*;
#(
  parameter int NUM_VINT = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  dpStrobes_t                       strb,
  input  logic [WORD_W-1:0]                wdata,
  output logic [NUM_VINT-1:0][WORD_W-1:0]  statusAll,
  output logic [NUM_VINT-1:0][WORD_W-1:0]  enableAll,
  output logic [NUM_VINT-1:0]              irqOut,
  output logic [WORD_W-1:0]                pageWord
);
  for (genvar v = 0; v < NUM_VINT; v++) begin : g_vint
    logic [WORD_W-1:0] statNext;
    logic pageSel;
    logic evtSel;
    assign pageSel = (strb.page == VIDX_W'(v));
    assign evtSel  = (strb.evtVint == VIDX_W'(v));

    always_comb begin
      statNext = statusAll[v];
      if (strb.regWr && strb.regKind == REG_STATUS && pageSel) statNext = statNext & ~wdata;
      if (evtSel && strb.evtClr) statNext[strb.evtBit] = 1'b0;
      if (evtSel && strb.evtSet) statNext[strb.evtBit] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        statusAll[v] <= '0;
        enableAll[v] <= '0;
        irqOut[v]    <= 1'b0;
      end else begin
        statusAll[v] <= statNext;
        if (strb.regWr && pageSel && strb.regKind == REG_EN_SET)
          enableAll[v] <= enableAll[v] | wdata;
        else if (strb.regWr && pageSel && strb.regKind == REG_EN_CLR)
          enableAll[v] <= enableAll[v] & ~wdata;
        irqOut[v] <= |(statusAll[v] & enableAll[v]);
      end
    end
  end

  always_comb begin
    pageWord = '0;
    for (int v = 0; v < NUM_VINT; v++) begin
      if (strb.page == VIDX_W'(v)) begin
        case (strb.regKind)
          REG_EN_SET, REG_EN_CLR: pageWord = enableAll[v];
          REG_STATUS:             pageWord = statusAll[v];
          default:                pageWord = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/evtagg_top.sv
module evtagg_top
  import evtagg_pkg::*;
#(
  parameter int NUM_VINT   = 4,
  parameter int NUM_EVENTS = 32,
  localparam int VINT_W    = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1,
  localparam int EVT_W     = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1,
  localparam int ADDR_W    = PAGE_SHIFT + VINT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [63:0]       busWdata,
  output logic [63:0]       busRdata,
  input  logic              evtValid,
  input  logic [EVT_W-1:0]  evtId,
  input  logic              evtDown,
  output logic [NUM_VINT-1:0] irqOut
);
  dpStrobes_t strb;
  logic [WORD_W-1:0] pageWord;
  logic [NUM_VINT-1:0][WORD_W-1:0] statusAll;
  logic [NUM_VINT-1:0][WORD_W-1:0] enableAll;

  evtagg_ctrl #(
    .NUM_VINT(NUM_VINT), .NUM_EVENTS(NUM_EVENTS),
    .VINT_W(VINT_W), .EVT_W(EVT_W), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .evtValid(evtValid), .evtId(evtId), .evtDown(evtDown),
    .pageWord(pageWord), .strb(strb)
  );

  evtagg_datapath #(.NUM_VINT(NUM_VINT)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .wdata(busWdata),
    .statusAll(statusAll), .enableAll(enableAll),
    .irqOut(irqOut), .pageWord(pageWord)
  );
endmodule

// File: rtl/evtagg_checker.sv
module evtagg_checker #(
  parameter int NUM_VINT = 4,
  parameter int ADDR_W   = 15
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           busValid,
  input logic                           busWrite,
  input logic [ADDR_W-1:0]              busAddr,
  input logic [63:0]                    busWdata,
  input logic                           evtValid,
  input logic [NUM_VINT-1:0]            irqOut,
  input logic [NUM_VINT-1:0][63:0]      statusAll,
  input logic [NUM_VINT-1:0][63:0]      enableAll
);
  for (genvar v = 0; v < NUM_VINT; v++) begin : g_chk
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(v * 4096);

    assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) |-> (statusAll[v] == '0 && enableAll[v] == '0 && !irqOut[v]));

    assert_en_set_R3: assert property (@(posedge clk) disable iff (rst)
      (busValid && busWrite && busAddr == BASE)
      |=> ((enableAll[v] & $past(busWdata)) == $past(busWdata)));

    assert_en_clr_R4: assert property (@(posedge clk) disable iff (rst)
      (busValid && busWrite && busAddr == (BASE | ADDR_W'(8)))
      |=> ((enableAll[v] & $past(busWdata)) == '0));

    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
      (busValid && busWrite && busAddr == (BASE | ADDR_W'(24)) && !evtValid)
      |=> ((statusAll[v] & $past(busWdata)) == '0));

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
      irqOut[v] == $past(|(statusAll[v] & enableAll[v])));
  end
endmodule

bind evtagg_top evtagg_checker #(.NUM_VINT(NUM_VINT), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .evtValid(evtValid),
  .irqOut(irqOut), .statusAll(statusAll), .enableAll(enableAll)
);

// File: tb/evtagg_tb.sv
module evtagg_top_tb_top;
  localparam int NV = 4;
  localparam int NE = 32;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [63:0] busWdata = '0;
  logic [63:0] busRdata;
  logic evtValid = 1'b0, evtDown = 1'b0;
  logic [4:0] evtId = '0;
  logic [NV-1:0] irqOut;

  int vectors = 0;
  int fails = 0;

  logic [63:0] expStat [NV];
  logic [63:0] expEn   [NV];
  logic        mValid  [NE];
  logic        mLevel  [NE];
  int          mVint   [NE];
  int          mBit    [NE];
  logic [63:0] mWord   [NE];

  always #5 clk = ~clk;

  evtagg_top #(.NUM_VINT(NV), .NUM_EVENTS(NE)) dut_i (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .evtValid(evtValid), .evtId(evtId), .evtDown(evtDown), .irqOut(irqOut)
  );

  function automatic logic [AW-1:0] pageAddr(int v, int off);
    return AW'(v * 4096 + off);
  endfunction

  function automatic logic [AW-1:0] mapAddr(int e);
    return AW'(16384 + e * 8);
  endfunction

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWr(logic [AW-1:0] a, logic [63:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic modelEvt(int id, logic down);
    if (mValid[id] && mVint[id] < NV) begin
      if (!down) expStat[mVint[id]][mBit[id]] = 1'b1;
      else if (mLevel[id]) expStat[mVint[id]][mBit[id]] = 1'b0;
    end
  endtask

  task automatic fireEvt(int id, logic down);
    @(negedge clk);
    evtValid = 1'b1; evtId = 5'(id); evtDown = down;
    @(negedge clk);
    evtValid = 1'b0;
    modelEvt(id, down);
  endtask

  task automatic progMap(int id, logic valid, logic level, int vint, int bpos);
    logic [63:0] w;
    w = '0;
    w[31] = valid; w[16] = level; w[15:8] = 8'(vint); w[5:0] = 6'(bpos);
    busWr(mapAddr(id), w);
    mValid[id] = valid; mLevel[id] = level; mVint[id] = vint; mBit[id] = bpos; mWord[id] = w;
  endtask

  task automatic checkStatus(string req);
    logic [63:0] d;
    for (int v = 0; v < NV; v++) begin
      busRd(pageAddr(v, 24), d);
      check64(req, $sformatf("status vint %0d", v), d, expStat[v]);
    end
  endtask

  task automatic checkIrq(string req);
    logic [NV-1:0] exp;
    @(negedge clk);
    for (int v = 0; v < NV; v++) exp[v] = |(expStat[v] & expEn[v]);
    check64(req, "irqOut", 64'(irqOut), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    for (int v = 0; v < NV; v++) begin expStat[v] = '0; expEn[v] = '0; end
    for (int e = 0; e < NE; e++) begin
      mValid[e] = 0; mLevel[e] = 0; mVint[e] = 0; mBit[e] = 0; mWord[e] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check64("R1", "irqOut after reset", 64'(irqOut), 64'd0);
    for (int v = 0; v < NV; v++) begin
      busRd(pageAddr(v, 0), d);  check64("R1", "enable after reset", d, 64'd0);
      busRd(pageAddr(v, 24), d); check64("R1", "status after reset", d, 64'd0);
    end
    for (int e = 0; e < NE; e++) begin
      busRd(mapAddr(e), d); check64("R1", "map after reset", d, 64'd0);
    end

    // R2: program every entry and read back
    for (int e = 0; e < NE; e++)
      progMap(e, 1'b1, (e % 3) == 0, e % NV, (e * 5 + e / 4) % 64);
    for (int e = 0; e < NE; e++) begin
      busRd(mapAddr(e), d); check64("R2", $sformatf("map entry %0d", e), d, mWord[e]);
    end

    // R3 / R4: enable set and clear sweep
    for (int v = 0; v < NV; v++) begin
      logic [63:0] ps, pc;
      ps = 64'hF0F0_1234_5678_9ABC ^ {16{4'(v)}};
      pc = 64'h0FF0_0000_FFFF_0003 << v;
      busWr(pageAddr(v, 0), ps); expEn[v] = expEn[v] | ps;
      busWr(pageAddr(v, 0), 64'h1);  expEn[v] = expEn[v] | 64'h1;
      busRd(pageAddr(v, 0), d); check64("R3", "enable via set offset", d, expEn[v]);
      busWr(pageAddr(v, 8), pc); expEn[v] = expEn[v] & ~pc;
      busRd(pageAddr(v, 8), d); check64("R4", "enable via clear offset", d, expEn[v]);
      busRd(pageAddr(v, 0), d); check64("R4", "enable after clear", d, expEn[v]);
    end

    // R5 / R7 / R10: up events on all entries
    for (int e = 0; e < NE; e++) begin
      fireEvt(e, 1'b0);
      checkIrq("R10");
    end
    checkStatus("R5");

    // R5 / R7: down events on all entries
    for (int e = 0; e < NE; e++) begin
      fireEvt(e, 1'b1);
      checkIrq("R10");
    end
    checkStatus("R7");

    // R6: write-1-to-clear sweep
    for (int e = 0; e < NE; e++) fireEvt(e, 1'b0);
    for (int v = 0; v < NV; v++) begin
      logic [63:0] p;
      p = 64'hAAAA_5555_CCCC_3333 >> v;
      busWr(pageAddr(v, 24), p); expStat[v] = expStat[v] & ~p;
      checkIrq("R10");
    end
    checkStatus("R6");

    // R8: event and clear of the same bit in one cycle (entry 1 is pulsed)
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = pageAddr(mVint[1], 24); busWdata = '1;
    evtValid = 1'b1; evtId = 5'd1; evtDown = 1'b0;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; evtValid = 1'b0;
    expStat[mVint[1]] = '0;
    expStat[mVint[1]][mBit[1]] = 1'b1;
    busRd(pageAddr(mVint[1], 24), d);
    check64("R8", "event beats clear", d, expStat[mVint[1]]);

    // R9: invalid entry and out-of-range target are dropped
    for (int v = 0; v < NV; v++) begin busWr(pageAddr(v, 24), '1); expStat[v] = '0; end
    progMap(2, 1'b0, 1'b0, 2, 9);
    progMap(4, 1'b1, 1'b0, 5, 17);
    fireEvt(2, 1'b0);
    fireEvt(4, 1'b0);
    checkStatus("R9");
    checkIrq("R9");

    // R12: redirect entry 2
    progMap(2, 1'b1, 1'b0, 3, 63);
    fireEvt(2, 1'b0);
    checkStatus("R12");
    check64("R12", "redirected bit", 64'(expStat[3][63]), 64'd1);

    // R11: undefined offset
    busWr(pageAddr(3, 16), '1);
    busRd(pageAddr(3, 16), d); check64("R11", "undefined offset read", d, 64'd0);
    busRd(pageAddr(3, 0), d);  check64("R11", "enable untouched", d, expEn[3]);
    busRd(pageAddr(3, 24), d); check64("R11", "status untouched", d, expStat[3]);

    // R10: make output fall by clearing enables
    busWr(pageAddr(3, 0), 64'h8000_0000_0000_0000); expEn[3] = expEn[3] | 64'h8000_0000_0000_0000;
    checkIrq("R10");
    check64("R10", "irq 3 high", 64'(irqOut[3]), 64'd1);
    busWr(pageAddr(3, 8), '1); expEn[3] = '0;
    check64("R10", "irq 3 still high one cycle", 64'(irqOut[3]), 64'd1);
    checkIrq("R10");
    check64("R10", "irq 3 low", 64'(irqOut[3]), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule